// File: doc/BRIEF.md
# Sleep-State Power Sequencer

This block is the digital core of a multi-rail power manager. Two active-low sleep request pins come in raw from the board. Each one passes through a counter-based glitch filter. The filtered pair is decoded into a requested system power level: running, suspend-to-RAM (S3) or soft-off (S4/S5). A small state machine tracks the current level and refuses the one move that is not allowed, from soft-off straight into suspend.

Two board straps are sampled once, when reset is released. From the tracked level and these straps the block drives two rail enables:

- a dual rail that stays up through suspend and may stay up through soft-off;
- a network rail that is either always on or only on while running.

Undervoltage flags from the controlled outputs, undervoltage flags from the two monitored supply inputs, and an overtemperature flag are merged into one registered fault output. Once that output is set, it stays set until reset.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: A new level on either sleep pin is accepted only after it has been present on DEGLITCH_CYC consecutive rising clock edges. A pulse shorter than that changes nothing at the outputs. A pulse of exactly DEGLITCH_CYC edges is accepted.
- R2: While reset is low, and after reset is released, `pwr_state` reads 0 (running) and both enables and `fault` are low. The enables stay low until both filters have accepted a first level, which is DEGLITCH_CYC edges after release, plus one more edge.
- R3: Both sleep pins are active low. If `slp5_n` is low, the request is soft-off. If `slp5_n` is high and `slp3_n` is low, the request is suspend. If both are high, the request is running. `pwr_state` encodes running as 0, suspend as 1 and soft-off as 2. From running or suspend, the state takes the request one edge after the filtered level changes.
- R4: From soft-off, a suspend request is ignored and the state stays 2. The state leaves soft-off only when both pins are high, and then it goes to running (0).
- R5: `en_dual` is high in running and in suspend. In soft-off it equals the sampled `strap_dual_keep`.
- R6: `en_lan` is always high when the sampled `strap_lan_always` is 1. When that strap is 0, `en_lan` is high only in running.
- R7: The straps are captured on the first clock edge after reset is released. Later changes to the strap pins have no effect on the enables.
- R8: `fault` goes high on the clock edge after any flag in `uv_out`, `uv_in3v`, `uv_in5v` or `over_temp` is high. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| slp3_n | input | 1 | Raw suspend request, active low |
| slp5_n | input | 1 | Raw soft-off request, active low |
| strap_dual_keep | input | 1 | Strap: keep the dual rail on in soft-off |
| strap_lan_always | input | 1 | Strap: keep the network rail on in every state |
| uv_out | input | NUM_UV | Undervoltage flags of the controlled outputs |
| uv_in3v | input | 1 | Undervoltage flag of the 3.3 V supply input |
| uv_in5v | input | 1 | Undervoltage flag of the 5 V supply input |
| over_temp | input | 1 | Overtemperature flag |
| en_dual | output | 1 | Dual rail enable |
| en_lan | output | 1 | Network rail enable |
| fault | output | 1 | Sticky fault indication |
| pwr_state | output | 2 | Tracked power level (0 running, 1 suspend, 2 soft-off) |

## Verification
A wrong filter count shows up as a state change that comes one or more edges early or late. A filter fault can also let a short pulse through. The bench catches both with pulses one edge shorter than the threshold and pulses exactly at the threshold, sampling the state on the exact edge where it should move. A wrong state machine transition becomes visible on `pwr_state` and on the rail enables one edge after the filtered level changes. Every pair of requests is swept for all four strap settings, so the illegal soft-off-to-suspend move and the strap-dependent enables are seen within a few cycles of the stimulus. A lost fault latch shows on the edge after a flag goes away.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
    typedef enum logic [1:0] {
        PS_RUN     = 2'd0,
        PS_SUSPEND = 2'd1,
        PS_OFF     = 2'd2
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        logic       run;
    } fsm_reg_s;

    typedef struct packed {
        logic dual_keep;
        logic lan_always;
        logic started;
        logic fault;
    } top_reg_s;
endpackage

// File: rtl/seq_glitch_filter.sv
module seq_glitch_filter #(
    parameter int THRESH = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic valid_o
);
    localparam int CW = $clog2(THRESH + 1);

    typedef struct packed {
        logic          cand;
        logic [CW-1:0] cnt;
        logic          level;
        logic          valid;
    } flt_s;

    flt_s flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (raw_i != flt_q.cand) begin
            flt_d.cand = raw_i;
            flt_d.cnt  = CW'(1);
        end else if (flt_q.cnt < CW'(THRESH)) begin
            flt_d.cnt = flt_q.cnt + CW'(1);
        end
        if (flt_d.cnt == CW'(THRESH)) begin
            flt_d.level = flt_d.cand;
            flt_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{cand: 1'b1, cnt: '0, level: 1'b1, valid: 1'b0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign level_o = flt_q.level;
    assign valid_o = flt_q.valid;

    // R1: an accepted level must match the raw pin on the edge that took it
    assert_level_follows_raw_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.valid && $past(flt_q.valid) && !$stable(flt_q.level)) |-> ($past(raw_i) == flt_q.level))
        else $error("filter level changed without matching raw input");
endmodule

// File: rtl/seq_state_fsm.sv
module seq_state_fsm
    import sleep_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slp3_lvl_n,
    input  logic       slp5_lvl_n,
    input  logic       lvl_valid,
    output pwr_state_e state_o,
    output logic       run_o
);
    fsm_reg_s fsm_d, fsm_q;
    pwr_state_e req;

    always_comb begin
        if (!slp5_lvl_n)      req = PS_OFF;
        else if (!slp3_lvl_n) req = PS_SUSPEND;
        else                  req = PS_RUN;
    end

    always_comb begin
        fsm_d = fsm_q;
        if (lvl_valid) begin
            fsm_d.run = 1'b1;
            case (fsm_q.state)
                PS_OFF:  if (req == PS_RUN) fsm_d.state = PS_RUN;
                default: fsm_d.state = req;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: PS_RUN, run: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.state;
    assign run_o   = fsm_q.run;

    // R4: soft-off never moves straight into suspend
    assert_no_off_to_suspend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == PS_OFF) |=> (fsm_q.state != PS_SUSPEND))
        else $error("illegal soft-off to suspend move");

    // R2: the state stays at running until the filters have a first level
    assert_idle_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fsm_q.run |-> (fsm_q.state == PS_RUN))
        else $error("state moved before filters were valid");
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
    import sleep_seq_pkg::*;
#(
    parameter int DEGLITCH_CYC = 250,
    parameter int NUM_UV       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slp3_n,
    input  logic              slp5_n,
    input  logic              strap_dual_keep,
    input  logic              strap_lan_always,
    input  logic [NUM_UV-1:0] uv_out,
    input  logic              uv_in3v,
    input  logic              uv_in5v,
    input  logic              over_temp,
    output logic              en_dual,
    output logic              en_lan,
    output logic              fault,
    output logic [1:0]        pwr_state
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] raw_pins, lvl, lvl_ok;
    assign raw_pins = {slp5_n, slp3_n};

    for (genvar g = 0; g < NPIN; g++) begin : g_flt
        seq_glitch_filter #(.THRESH(DEGLITCH_CYC)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_pins[g]),
            .level_o(lvl[g]),
            .valid_o(lvl_ok[g])
        );
    end

    pwr_state_e state;
    logic       run;

    seq_state_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slp3_lvl_n(lvl[0]),
        .slp5_lvl_n(lvl[1]),
        .lvl_valid (&lvl_ok),
        .state_o   (state),
        .run_o     (run)
    );

    top_reg_s top_d, top_q;
    logic     any_flag;

    assign any_flag = (|uv_out) | uv_in3v | uv_in5v | over_temp;

    always_comb begin
        top_d = top_q;
        if (!top_q.started) begin
            top_d.started    = 1'b1;
            top_d.dual_keep  = strap_dual_keep;
            top_d.lan_always = strap_lan_always;
        end
        top_d.fault = top_q.fault | any_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign en_dual   = run & ((state != PS_OFF) | top_q.dual_keep);
    assign en_lan    = run & (top_q.lan_always | (state == PS_RUN));
    assign fault     = top_q.fault;
    assign pwr_state = state;

    // R8: any flag sets the fault on the next edge
    assert_fault_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_flag |=> fault)
        else $error("fault not set after flag");

    // R8: fault is sticky
    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault)
        else $error("fault cleared without reset");

    // R7: straps frozen after capture
    assert_straps_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        top_q.started |=> ($stable(top_q.dual_keep) && $stable(top_q.lan_always)))
        else $error("strap changed after capture");
endmodule

// File: tb/sleep_seq_ctrl_tb.sv
module sleep_seq_ctrl_tb;
    localparam int TH  = 4;
    localparam int NUV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slp3_n = 1'b1, slp5_n = 1'b1;
    logic s_dual = 1'b0, s_lan = 1'b0;
    logic [NUV-1:0] uv_out = '0;
    logic uv_in3v = 1'b0, uv_in5v = 1'b0, over_temp = 1'b0;
    logic en_dual, en_lan, fault;
    logic [1:0] pwr_state;

    int checks = 0;
    int errors = 0;
    int exp_state = 0;
    bit cfg_dual, cfg_lan;

    always #4 clk = ~clk;

    sleep_seq_ctrl #(.DEGLITCH_CYC(TH), .NUM_UV(NUV)) u_dut (
        .clk(clk), .rst_n(rst_n), .slp3_n(slp3_n), .slp5_n(slp5_n),
        .strap_dual_keep(s_dual), .strap_lan_always(s_lan),
        .uv_out(uv_out), .uv_in3v(uv_in3v), .uv_in5v(uv_in5v), .over_temp(over_temp),
        .en_dual(en_dual), .en_lan(en_lan), .fault(fault), .pwr_state(pwr_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " state"}, int'(pwr_state), exp_state);
        chk({tag, " R5 en_dual"}, int'(en_dual), int'(exp_state != 2 || cfg_dual));
        chk({tag, " R6 en_lan"}, int'(en_lan), int'(cfg_lan || exp_state == 0));
    endtask

    task automatic do_reset(input bit d, input bit l);
        @(negedge clk);
        rst_n = 1'b0; s_dual = d; s_lan = l;
        slp3_n = 1'b1; slp5_n = 1'b1;
        uv_out = '0; uv_in3v = 1'b0; uv_in5v = 1'b0; over_temp = 1'b0;
        cfg_dual = d; cfg_lan = l; exp_state = 0;
        repeat (3) @(negedge clk);
        chk("R2 reset en_dual", int'(en_dual), 0);
        chk("R2 reset en_lan", int'(en_lan), 0);
        chk("R2 reset fault", int'(fault), 0);
        chk("R2 reset state", int'(pwr_state), 0);
        rst_n = 1'b1;
        repeat (TH) @(negedge clk);
        chk("R2 enables low before first level", int'(en_dual | en_lan), 0);
        @(negedge clk);
        check_outputs("R2 after startup");
    endtask

    task automatic apply_req(input int r);
        int nxt;
        case (r)
            0: begin slp3_n = 1'b1; slp5_n = 1'b1; end
            1: begin slp3_n = 1'b0; slp5_n = 1'b1; end
            2: begin slp3_n = 1'b0; slp5_n = 1'b0; end
            default: begin slp3_n = 1'b1; slp5_n = 1'b0; end
        endcase
        nxt = (r == 0) ? 0 : (r == 1) ? 1 : 2;
        if (exp_state == 2) exp_state = (nxt == 0) ? 0 : 2;
        else exp_state = nxt;
        repeat (TH + 2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R3/R4/R5/R6: every pair of requests under every strap setting
        for (int cfg = 0; cfg < 4; cfg++) begin
            do_reset(cfg[0], cfg[1]);
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    apply_req(a);
                    check_outputs("R3 first step");
                    apply_req(b);
                    check_outputs((a >= 2 && b == 1) ? "R4 off ignores suspend" : "R3 second step");
                end
            end
        end

        // R1: short pulse rejected, threshold pulse accepted on exact edge
        do_reset(1'b0, 1'b0);
        slp5_n = 1'b0;
        repeat (TH - 1) @(negedge clk);
        slp5_n = 1'b1;
        repeat (TH + 2) @(negedge clk);
        chk("R1 short pulse state", int'(pwr_state), 0);
        chk("R1 short pulse en_lan", int'(en_lan), 1);
        slp5_n = 1'b0;
        repeat (TH) @(negedge clk);
        slp5_n = 1'b1;
        chk("R1 not yet moved", int'(pwr_state), 0);
        @(negedge clk);
        chk("R1 threshold pulse accepted", int'(pwr_state), 2);
        chk("R1 threshold pulse en_lan", int'(en_lan), 0);
        repeat (TH + 2) @(negedge clk);
        chk("R4 returns to running", int'(pwr_state), 0);

        // R7: strap pins changed after capture have no effect
        do_reset(1'b1, 1'b1);
        s_dual = 1'b0; s_lan = 1'b0;
        apply_req(2);
        check_outputs("R7 straps ignored");
        apply_req(0);
        check_outputs("R7 straps ignored back");

        // R8: each flag alone sets a sticky fault
        for (int f = 0; f < NUV + 3; f++) begin
            do_reset(1'b0, 1'b0);
            chk("R8 no flag no fault", int'(fault), 0);
            if (f < NUV) uv_out[f] = 1'b1;
            else if (f == NUV) uv_in3v = 1'b1;
            else if (f == NUV + 1) uv_in5v = 1'b1;
            else over_temp = 1'b1;
            @(negedge clk);
            uv_out = '0; uv_in3v = 1'b0; uv_in5v = 1'b0; over_temp = 1'b0;
            chk("R8 fault set", int'(fault), 1);
            repeat (3) @(negedge clk);
            chk("R8 fault sticky", int'(fault), 1);
        end
        do_reset(1'b0, 1'b0);
        chk("R8 fault cleared by reset", int'(fault), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule